// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds one 8-bit control register and runs the low-power sequence of a small microcontroller. The CPU writes the register through a plain write strobe and reads it back at any time. When the CPU raises a sleep request, the register picks the target mode:

- **Light sleep** ends as soon as an enabled interrupt or a non-maskable wake pulse arrives.
- **Deep standby** ends only on the selected edge of the non-maskable interrupt pin. After that edge, an oscillator-settling delay runs before the CPU may resume.

While in standby, the register also decides how the external bus looks. The address and control outputs either float, or the address is held and the control strobes are parked high. Two further register bits are exported as flags: one enables on-chip RAM, the other sets the user-bit mode of the condition code.

The settling delay comes from a 3-bit code. The table is not monotonic, and one code is illegal. The illegal code falls back to the longest delay and sets a sticky error flag. The parameter `DIV_LOG2` divides every delay by a power of two, so shorter runs are possible in a test environment. The oscillator, clock tree, interrupt priority and the CPU itself are outside the block.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After a synchronous reset:
  - `cfg_rdata` reads 8'h09.
  - `cpu_run` is 1 and `pwr_state` is 0 (run).
  - `settle_err` is 0.
  - `ram_en` and `ubit_mode` are 1.
  - `addr_oe` and `ctl_oe` are 1.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the register at that edge, and `cfg_rdata` shows it from then on. The bit layout is:
  - bit 7: standby select
  - bits 6:4: settling code
  - bit 3: user-bit mode, exported as `ubit_mode`
  - bit 2: wake edge
  - bit 1: bus keep in standby
  - bit 0: RAM enable, exported as `ram_en`
- R3: In run state with bit 7 = 0, a cycle with `sleep_req` high moves `pwr_state` to 1 (sleep) at that edge, and `cpu_run` drops to 0 at the same edge.
- R4: In run state with bit 7 = 1, `sleep_req` moves `pwr_state` to 2 (standby). The bit-7 value used is the one held before any write in the same cycle.
- R5: In sleep, a cycle with `irq_req` or `nmi_req` high returns the block to run at that edge. No delay is added.
- R6: `nmi_in` passes through a 2-stage synchroniser.
  - With bit 2 = 0, a falling edge produces a wake request; with bit 2 = 1, a rising edge does.
  - Each such edge gives exactly one 1-cycle `nmi_req` pulse, 3 edges after the input change.
  - A held level gives no pulse, and changing bit 2 while the level is steady gives no pulse.
- R7: In standby, `irq_req` and `sleep_req` have no effect. Only `nmi_req` leaves standby, moving to state 3 (settle).
- R8: Settle lasts exactly `N >> DIV_LOG2` cycles, with `cpu_run` low throughout, before the return to run. N by code:

  | Code | N |
  |---|---|
  | 0 | 8192 |
  | 1 | 16384 |
  | 2 | 32768 |
  | 3 | 65536 |
  | 4 | 131072 |
  | 5 | 262144 |
  | 6 | 1024 |

  The code is captured when standby is entered, so later writes do not change the running delay.
- R9: Code 7 at standby entry uses N = 262144 and sets `settle_err`. The flag stays at 1 until reset.
- R10: In standby or settle with bit 1 = 0, `addr_oe` and `ctl_oe` are 0.
- R11: In standby or settle with bit 1 = 1:
  - `addr_oe` is 1 and `addr_out` holds the last address driven in run or sleep.
  - `ctl_out` is all ones and `ctl_oe` is 1.
- R12: Outside standby and settle, `addr_out` and `ctl_out` follow `addr_in` and `ctl_in` with one cycle of delay, with both enables at 1.
- R13: In sleep or settle, `sleep_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read value |
| sleep_req | input | 1 | CPU asks to enter low power |
| irq_req | input | 1 | Enabled maskable interrupt pending |
| nmi_in | input | 1 | Asynchronous non-maskable interrupt pin |
| nmi_req | output | 1 | One-cycle pulse on the selected pin edge |
| addr_in | input | AW | Address from the CPU |
| ctl_in | input | CW | Bus control strobes from the CPU (active low) |
| addr_out | output | AW | Address to the pins |
| addr_oe | output | 1 | Address output enable |
| ctl_out | output | CW | Control strobes to the pins |
| ctl_oe | output | 1 | Control output enable |
| cpu_run | output | 1 | CPU clock may run |
| pwr_state | output | 2 | 0 run, 1 sleep, 2 standby, 3 settle |
| ram_en | output | 1 | On-chip RAM enable |
| ubit_mode | output | 1 | Condition-code bit 6 is a user bit |
| settle_err | output | 1 | Sticky flag for the illegal settling code |

## Verification
A register write and a sleep request can share one clock edge. The mode choice must then use the bit 7 held before the write. The bench provokes this by writing a value with bit 7 cleared in the same cycle as `sleep_req` while bit 7 is set, and expects standby rather than sleep.

A second collision is a register write that lands during standby or settle. That write changes the settling code or the bus-keep bit while the sequence is already running. The reference model, updated on every clock, judges both cases: it applies the write only after the cycle's decisions are taken. The bench also expects the delay latched at entry to stay in force.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int unsigned CFG_W    = 8;
  localparam int unsigned SETTLE_W = 19;

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_STBY   = 2'd2,
    PM_SETTLE = 2'd3
  } pm_state_e;

  // Bit positions inside the control register
  localparam int unsigned B_STBY = 7;
  localparam int unsigned B_CODE = 4;
  localparam int unsigned B_UBIT = 3;
  localparam int unsigned B_EDGE = 2;
  localparam int unsigned B_KEEP = 1;
  localparam int unsigned B_RAM  = 0;

  localparam logic [CFG_W-1:0] CFG_RESET = 8'h09;
  localparam logic [2:0]       CODE_BAD  = 3'd7;
  localparam logic [2:0]       CODE_MAX  = 3'd5;

  // Full-rate settling count for a legal code (0..6)
  function automatic logic [SETTLE_W-1:0] settle_base(input logic [2:0] code);
    logic [SETTLE_W-1:0] unit;
    unit = SETTLE_W'(1);
    if (code == 3'd6) return unit << 10;
    return unit << (13 + 32'(code));
  endfunction

endpackage

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg
  import pwr_mode_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = CFG_RESET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/pmc_edge_det.sv
module pmc_edge_det #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_LVL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic pulse
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   hit;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= IDLE_LVL;
          else     sync_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= IDLE_LVL;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  // Edge is judged on a transition of the synchronised level only
  always_comb begin
    if (rise_sel) hit = sync_q[LAST] & ~prev_q;
    else          hit = ~sync_q[LAST] & prev_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= IDLE_LVL;
      pulse  <= 1'b0;
    end else begin
      prev_q <= sync_q[LAST];
      pulse  <= hit;
    end
  end

endmodule

// File: rtl/pmc_settle_cnt.sv
module pmc_settle_cnt
  import pwr_mode_pkg::*;
#(
  parameter int unsigned DIV_LOG2 = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [2:0] code,
  input  logic       run_dn,
  output logic       last
);

  logic [SETTLE_W-1:0] cnt_q;
  logic [SETTLE_W-1:0] load_val;

  always_comb load_val = settle_base(code) >> DIV_LOG2;

  always_ff @(posedge clk) begin
    if (rst)                         cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (run_dn && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == SETTLE_W'(1));

endmodule

// File: rtl/pmc_bus_park.sv
module pmc_bus_park #(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          parked,
  input  logic          keep,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] ctl_in,
  output logic [AW-1:0] addr_out,
  output logic          addr_oe,
  output logic [CW-1:0] ctl_out,
  output logic          ctl_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      addr_oe  <= 1'b1;
      ctl_out  <= '1;
      ctl_oe   <= 1'b1;
    end else if (!parked) begin
      addr_out <= addr_in;
      addr_oe  <= 1'b1;
      ctl_out  <= ctl_in;
      ctl_oe   <= 1'b1;
    end else if (keep) begin
      addr_oe  <= 1'b1;
      ctl_out  <= '1;
      ctl_oe   <= 1'b1;
    end else begin
      addr_oe  <= 1'b0;
      ctl_oe   <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned AW          = 24,
  parameter int unsigned CW          = 4,
  parameter int unsigned DIV_LOG2    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             sleep_req,
  input  logic             irq_req,
  input  logic             nmi_in,
  output logic             nmi_req,
  input  logic [AW-1:0]    addr_in,
  input  logic [CW-1:0]    ctl_in,
  output logic [AW-1:0]    addr_out,
  output logic             addr_oe,
  output logic [CW-1:0]    ctl_out,
  output logic             ctl_oe,
  output logic             cpu_run,
  output logic [1:0]       pwr_state,
  output logic             ram_en,
  output logic             ubit_mode,
  output logic             settle_err
);

  logic [CFG_W-1:0] cfg_q;
  pm_state_e        st_q, st_d;
  logic             enter_stby;
  logic             load_cnt;
  logic             cnt_last;
  logic [2:0]       code_now;
  logic [2:0]       code_q;
  logic             parked_d;

  pmc_cfg_reg #(.RST_VAL(CFG_RESET)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  pmc_edge_det #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .pin      (nmi_in),
    .rise_sel (cfg_q[B_EDGE]),
    .pulse    (nmi_req)
  );

  assign code_now = cfg_q[B_CODE +: 3];

  always_comb begin
    st_d       = st_q;
    enter_stby = 1'b0;
    load_cnt   = 1'b0;
    unique case (st_q)
      PM_RUN: begin
        if (sleep_req) begin
          if (cfg_q[B_STBY]) begin
            st_d       = PM_STBY;
            enter_stby = 1'b1;
          end else begin
            st_d = PM_SLEEP;
          end
        end
      end
      PM_SLEEP: begin
        if (irq_req || nmi_req) st_d = PM_RUN;
      end
      PM_STBY: begin
        if (nmi_req) begin
          st_d     = PM_SETTLE;
          load_cnt = 1'b1;
        end
      end
      PM_SETTLE: begin
        if (cnt_last) st_d = PM_RUN;
      end
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= PM_RUN;
      cpu_run    <= 1'b1;
      code_q     <= 3'd0;
      settle_err <= 1'b0;
    end else begin
      st_q    <= st_d;
      cpu_run <= (st_d == PM_RUN);
      if (enter_stby) begin
        code_q <= (code_now == CODE_BAD) ? CODE_MAX : code_now;
        if (code_now == CODE_BAD) settle_err <= 1'b1;
      end
    end
  end

  pmc_settle_cnt #(.DIV_LOG2(DIV_LOG2)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .load   (load_cnt),
    .code   (code_q),
    .run_dn (st_q == PM_SETTLE),
    .last   (cnt_last)
  );

  assign parked_d = (st_d == PM_STBY) || (st_d == PM_SETTLE);

  pmc_bus_park #(.AW(AW), .CW(CW)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .parked   (parked_d),
    .keep     (cfg_q[B_KEEP]),
    .addr_in  (addr_in),
    .ctl_in   (ctl_in),
    .addr_out (addr_out),
    .addr_oe  (addr_oe),
    .ctl_out  (ctl_out),
    .ctl_oe   (ctl_oe)
  );

  assign cfg_rdata = cfg_q;
  assign pwr_state = st_q;
  assign ram_en    = cfg_q[B_RAM];
  assign ubit_mode = cfg_q[B_UBIT];

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_req,
  input logic          nmi_req,
  input logic [1:0]    pwr_state,
  input logic          cpu_run,
  input logic          settle_err,
  input logic [AW-1:0] addr_out,
  input logic          addr_oe,
  input logic [CW-1:0] ctl_out,
  input logic          ctl_oe
);

  // R8
  run_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_run == (pwr_state == 2'd0));

  // R6
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> !nmi_req);

  // R5
  sleep_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd1) && (irq_req || nmi_req) |=> (pwr_state == 2'd0));

  // R7
  stby_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd2) && !nmi_req |=> (pwr_state == 2'd2));

  // R7
  stby_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd2) && nmi_req |=> (pwr_state == 2'd3));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    settle_err |=> settle_err);

  // R11
  strobe_park_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd2) && addr_oe |-> (ctl_out == {CW{1'b1}}) && ctl_oe);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd2) && $past(pwr_state == 2'd2) && addr_oe |-> $stable(addr_out));

  // R10
  float_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state[1]) && !addr_oe |-> !ctl_oe);

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_req    (irq_req),
  .nmi_req    (nmi_req),
  .pwr_state  (pwr_state),
  .cpu_run    (cpu_run),
  .settle_err (settle_err),
  .addr_out   (addr_out),
  .addr_oe    (addr_oe),
  .ctl_out    (ctl_out),
  .ctl_oe     (ctl_oe)
);

// File: tb/pwr_mode_ctl_bench.sv
module pwr_mode_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int CW  = 4;
  localparam int DIV = 6;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = 8'h00;
  logic [7:0]    cfg_rdata;
  logic          sleep_req = 1'b0;
  logic          irq_req = 1'b0;
  logic          nmi_in = 1'b1;
  logic          nmi_req;
  logic [AW-1:0] addr_in = '0;
  logic [CW-1:0] ctl_in = '0;
  logic [AW-1:0] addr_out;
  logic          addr_oe;
  logic [CW-1:0] ctl_out;
  logic          ctl_oe;
  logic          cpu_run;
  logic [1:0]    pwr_state;
  logic          ram_en;
  logic          ubit_mode;
  logic          settle_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int pulses = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctl #(.AW(AW), .CW(CW), .DIV_LOG2(DIV), .SYNC_STAGES(2)) u_pwr_mode_ctl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sleep_req(sleep_req), .irq_req(irq_req), .nmi_in(nmi_in), .nmi_req(nmi_req),
    .addr_in(addr_in), .ctl_in(ctl_in), .addr_out(addr_out), .addr_oe(addr_oe),
    .ctl_out(ctl_out), .ctl_oe(ctl_oe), .cpu_run(cpu_run), .pwr_state(pwr_state),
    .ram_en(ram_en), .ubit_mode(ubit_mode), .settle_err(settle_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]    m_reg;
  int            m_st, m_cnt, m_code;
  logic          m_run, m_err, m_nreq;
  logic          s1, s2, pv;
  logic [AW-1:0] m_addr;
  logic          m_aoe, m_coe;
  logic [CW-1:0] m_ctl;

  function automatic int wait_of(input int code);
    int n;
    case (code)
      0: n = 8192;    1: n = 16384;   2: n = 32768;  3: n = 65536;
      4: n = 131072;  5: n = 262144;  6: n = 1024;   default: n = 262144;
    endcase
    return n >> DIV;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg = 8'h09; m_st = 0; m_cnt = 0; m_code = 0; m_run = 1; m_err = 0; m_nreq = 0;
      s1 = 1; s2 = 1; pv = 1; m_addr = '0; m_aoe = 1; m_ctl = '1; m_coe = 1;
    end else begin
      logic n_req;
      int   n_st;
      bit   park;
      n_req = m_reg[2] ? (s2 && !pv) : (!s2 && pv);
      pv = s2; s2 = s1; s1 = nmi_in;
      n_st = m_st;
      case (m_st)
        0: if (sleep_req) begin
             if (m_reg[7]) begin
               n_st = 2;
               if (m_reg[6:4] == 3'd7) begin m_code = 5; m_err = 1; end
               else m_code = int'(m_reg[6:4]);
             end else n_st = 1;
           end
        1: if (irq_req || m_nreq) n_st = 0;
        2: if (m_nreq) begin n_st = 3; m_cnt = wait_of(m_code); end
        default: if (m_cnt == 1) n_st = 0; else m_cnt--;
      endcase
      park = (n_st >= 2);
      if (!park) begin m_addr = addr_in; m_aoe = 1; m_ctl = ctl_in; m_coe = 1; end
      else if (m_reg[1]) begin m_aoe = 1; m_ctl = '1; m_coe = 1; end
      else begin m_aoe = 0; m_coe = 0; end
      if (cfg_we) m_reg = cfg_wdata;
      m_st = n_st; m_run = (n_st == 0); m_nreq = n_req;
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (nmi_req === 1'b1) pulses++;
    if (!rst && !done) begin
      check("R2 cfg_rdata", cfg_rdata, m_reg);
      check("R2 ram_en", ram_en, m_reg[0]);
      check("R2 ubit_mode", ubit_mode, m_reg[3]);
      check("R4 pwr_state", pwr_state, m_st);
      check("R8 cpu_run", cpu_run, m_run);
      check("R6 nmi_req", nmi_req, m_nreq);
      check("R9 settle_err", settle_err, m_err);
      check("R10 addr_oe", addr_oe, m_aoe);
      check("R10 ctl_oe", ctl_oe, m_coe);
      if (m_aoe) check("R12 addr_out", addr_out, m_addr);
      if (m_coe) check("R11 ctl_out", ctl_out, m_ctl);
    end
  end

  // bus traffic from the CPU side
  initial begin
    forever begin
      @(negedge clk);
      addr_in = addr_in * 16'd5 + 16'd7;
      ctl_in  = ctl_in + 4'd3;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v; tick(1); cfg_we = 0;
  endtask

  task automatic go_sleep();
    sleep_req = 1; tick(1); sleep_req = 0;
  endtask

  // drive the wake level, then measure settle cycles
  task automatic wake_and_time(input logic lvl, input int exp_len, input string req);
    int n = 0;
    int guard = 0;
    nmi_in = lvl;
    while (pwr_state != 2'd3 && guard < 12) begin tick(1); guard++; end
    check({req, " enter settle"}, pwr_state, 2'd3);
    while (pwr_state == 2'd3 && n < 300000) begin tick(1); n++; end
    check({req, " settle length"}, n, exp_len);
    check({req, " back to run"}, cpu_run, 1'b1);
  endtask

  initial begin
    int p0;
    logic [AW-1:0] held;
    tick(4);
    rst = 0;
    tick(1);
    // R1
    check("R1 reset reg", cfg_rdata, 8'h09);
    check("R1 reset run", cpu_run, 1'b1);
    check("R1 reset state", pwr_state, 2'd0);
    check("R1 reset err", settle_err, 1'b0);
    check("R1 reset oe", {addr_oe, ctl_oe}, 2'b11);

    // R2
    wr(8'h02);
    check("R2 readback", cfg_rdata, 8'h02);
    check("R2 ram_en bit0", ram_en, 1'b0);
    check("R2 ubit bit3", ubit_mode, 1'b0);
    wr(8'h09);

    // R3, R13, R5: sleep, ignored second request, irq exit
    go_sleep();
    check("R3 sleep state", pwr_state, 2'd1);
    check("R3 cpu halted", cpu_run, 1'b0);
    sleep_req = 1; tick(3); sleep_req = 0;
    check("R13 still sleeping", pwr_state, 2'd1);
    irq_req = 1; tick(1); irq_req = 0;
    check("R5 irq wake", pwr_state, 2'd0);

    // R6: falling edge wakes sleep, exactly one pulse
    go_sleep();
    p0 = pulses;
    nmi_in = 0; tick(3);
    check("R6 pulse timing", nmi_req, 1'b1);
    tick(1);
    check("R5 nmi wake", pwr_state, 2'd0);
    tick(8);
    check("R6 single pulse", pulses - p0, 1);
    // level held, then edge select flipped while steady: no pulse
    p0 = pulses;
    wr(8'h0D); tick(6); wr(8'h09); tick(6);
    check("R6 no pulse on level", pulses - p0, 0);
    nmi_in = 1; tick(6);
    check("R6 wrong edge ignored", pulses - p0, 0);

    // R7, R10, R8: standby with floating bus, code 6
    wr(8'hE9);
    go_sleep();
    check("R4 standby state", pwr_state, 2'd2);
    check("R10 address floats", addr_oe, 1'b0);
    check("R10 strobes float", ctl_oe, 1'b0);
    irq_req = 1; sleep_req = 1; tick(4); irq_req = 0; sleep_req = 0;
    check("R7 irq ignored", pwr_state, 2'd2);
    wake_and_time(1'b0, 1024 >> DIV, "R8 code6");

    // R11: keep bus, rising edge, code 0; code written during standby is ignored
    nmi_in = 0;
    wr(8'h8F);
    tick(6);
    go_sleep();
    held = addr_out;
    tick(5);
    check("R11 addr held", addr_out, held);
    check("R11 strobes high", ctl_out, 4'hF);
    check("R11 addr driven", addr_oe, 1'b1);
    wr(8'hEF);
    wake_and_time(1'b1, 8192 >> DIV, "R8 latched code");
    tick(2);
    check("R12 addr follows", addr_oe, 1'b1);

    // R8: remaining legal codes
    for (int c = 1; c <= 5; c++) begin
      nmi_in = 0;
      wr(8'h8F | 8'(c << 4));
      tick(6);
      go_sleep();
      tick(2);
      wake_and_time(1'b1, wait_of(c), "R8 table");
    end

    // R9: illegal code
    nmi_in = 0;
    wr(8'hF5);
    tick(6);
    go_sleep();
    check("R9 error set", settle_err, 1'b1);
    wake_and_time(1'b1, 262144 >> DIV, "R9 longest wait");
    wr(8'h09);
    check("R9 error sticky", settle_err, 1'b1);

    // R4: write and request in the same cycle use the old bit 7
    nmi_in = 1;
    wr(8'h89);
    tick(6);
    cfg_we = 1; cfg_wdata = 8'h09; sleep_req = 1;
    tick(1);
    cfg_we = 0; sleep_req = 0;
    check("R4 old select used", pwr_state, 2'd2);
    wake_and_time(1'b0, 8192 >> DIV, "R4 exit");

    // reset clears the sticky flag
    rst = 1; tick(2); rst = 0; tick(1);
    check("R1 err cleared", settle_err, 1'b0);

    tick(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule